// File: doc/BRIEF.md
# Block-Granular Circular Staging Buffer

This block stages a stream of data items between a burst transfer engine and a processing stage that consumes fixed-size groups of items. It stores items in a two-port RAM, organised as a ring of `NUM_SLOTS` slots of `BLK_ITEMS` items each. One RAM port only writes and takes items from the producer. The other port only reads and unloads a whole slot into a wide output register for the consumer.

Occupancy is counted in whole blocks. A block counts as present only after its last item has been written. The producer is stalled with `wr_ready` while every slot holds an unconsumed block. It is released again as soon as the consumer finishes unloading a slot. A producer can close a block early with `wr_last`. The buffer then records how many items that block holds, so that the consumer can pad the remaining lanes. Writing and unloading run at the same time on their own ports. When a block is committed and another is released in the same cycle, occupancy stays the same.

Top module: `blk_ring_buf`

## Requirements
- R1: After reset, `buf_empty`=1, `buf_full`=0, `wr_ready`=1, `rd_busy`=0 and `out_valid`=0.
- R2: An item is taken at a clock edge where `wr_valid` and `wr_ready` are both 1. Items fill the current block in order. The block is committed at the edge that takes its `BLK_ITEMS`-th item. `buf_empty` falls in the cycle after the commit edge, and not while the block is incomplete.
- R3: An item taken with `wr_last`=1 commits the block early. The block's count is the number of items taken into it (1 to `BLK_ITEMS`), and `out_count` reports that count when the block is unloaded.
- R4: `rd_req`=1 at an edge where `buf_empty`=0 and `rd_busy`=0 starts an unload, and `rd_busy` is 1 in the next cycle. `out_valid` is a one-cycle pulse that rises `BLK_ITEMS`+1 edges after the start edge. Lane i of `out_data` (bits i*`DATA_W` upward) then holds item i of the unloaded block.
- R5: Blocks are unloaded in the order they were committed, including across the wrap of the ring.
- R6: With `NUM_SLOTS` blocks committed and not released, `buf_full`=1 and `wr_ready`=0. Items offered in that state are dropped and create no block.
- R7: The unload releases its slot at the edge that raises `out_valid`. In that same cycle `wr_ready` is 1 and `buf_full` is 0.
- R8: A block commit and a slot release at the same edge leave the occupancy unchanged.
- R9: `rd_req` is ignored while `buf_empty`=1. No unload starts and no `out_valid` follows.
- R10: Items can be written while an unload is in progress, and the block being unloaded is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers an item |
| wr_data | input | DATA_W | Item value |
| wr_last | input | 1 | Item closes the current block early |
| wr_ready | output | 1 | Buffer accepts items (not full) |
| rd_req | input | 1 | Consumer asks to unload the oldest block |
| rd_busy | output | 1 | Unload in progress |
| out_valid | output | 1 | One-cycle pulse: out_data and out_count are fresh |
| out_data | output | BLK_ITEMS*DATA_W | Unloaded block, item i in lane i |
| out_count | output | $clog2(BLK_ITEMS+1) | Valid items in the unloaded block |
| buf_full | output | 1 | All slots hold committed blocks |
| buf_empty | output | 1 | No committed block is waiting |

## Verification
An unload delivers its result `BLK_ITEMS`+1 edges after the edge that accepts `rd_req`. The bench counts those edges exactly and checks that `out_valid` is still low one edge earlier and is high at the due edge. A commit shows on `buf_empty` and `buf_full` one edge after the item that closes the block. Each check samples at the falling edge that follows the edge concerned. The commit/release test places the final item of a new block on the release edge, then checks the full flag at that same sample point and again after one more block has been written.

// File: rtl/blk_ring_pkg.sv
package blk_ring_pkg;

   typedef enum logic [1:0] {
      UNLD_IDLE  = 2'd0,
      UNLD_FETCH = 2'd1,
      UNLD_DRAIN = 2'd2
   } unld_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/blk_ring_ram.sv
module blk_ring_ram #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wen,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             ren,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   // write-only port
   always_ff @(posedge clk) begin
      if (wen) store[waddr] <= wdata;
   end

   // read-only port, one cycle of latency
   always_ff @(posedge clk) begin
      if (ren) rdata <= store[raddr];
   end

endmodule

// File: rtl/blk_ring_wr_ctrl.sv
module blk_ring_wr_ctrl #(
   parameter int NUM_SLOTS = 4,
   parameter int BLK_ITEMS = 4,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int PTR_W    = SLOT_W + 1,
   localparam int IDX_W    = $clog2(BLK_ITEMS),
   localparam int CNT_W    = $clog2(BLK_ITEMS + 1),
   localparam int AW       = $clog2(NUM_SLOTS * BLK_ITEMS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_last,
   input  logic              space_ok,
   output logic              ram_we,
   output logic [AW-1:0]     ram_waddr,
   output logic [PTR_W-1:0]  wptr,
   output logic              commit,
   input  logic [SLOT_W-1:0] cnt_slot,
   output logic [CNT_W-1:0]  cnt_val
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_ITEMS - 1);

   logic [IDX_W-1:0] fill_idx;
   logic [CNT_W-1:0] cnt_q [NUM_SLOTS];
   logic             take;

   assign take      = wr_valid && space_ok;
   assign commit    = take && ((fill_idx == LAST_IDX) || wr_last);
   assign ram_we    = take;
   assign ram_waddr = AW'(int'(wptr[SLOT_W-1:0]) * BLK_ITEMS + int'(fill_idx));
   assign cnt_val   = cnt_q[cnt_slot];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_idx <= '0;
         wptr     <= '0;
      end else if (commit) begin
         fill_idx <= '0;
         wptr     <= wptr + PTR_W'(1);
      end else if (take) begin
         fill_idx <= fill_idx + IDX_W'(1);
      end
   end

   // per-slot valid item count, written when a block is committed
   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cnt
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q[s] <= '0;
            else if (commit && (wptr[SLOT_W-1:0] == SLOT_W'(s)))
               cnt_q[s] <= CNT_W'(fill_idx) + CNT_W'(1);
         end
      end
   endgenerate

   // a block can never hold more items than a slot has lanes
   assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !commit) |=> (fill_idx != '0))
      else $error("fill index wrapped without a commit");

endmodule

// File: rtl/blk_ring_rd_ctrl.sv
module blk_ring_rd_ctrl
   import blk_ring_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NUM_SLOTS = 4,
   parameter int BLK_ITEMS = 4,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int PTR_W    = SLOT_W + 1,
   localparam int IDX_W    = $clog2(BLK_ITEMS),
   localparam int CNT_W    = $clog2(BLK_ITEMS + 1),
   localparam int AW       = $clog2(NUM_SLOTS * BLK_ITEMS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_req,
   input  logic                        blk_present,
   output logic                        ram_re,
   output logic [AW-1:0]               ram_raddr,
   input  logic [DATA_W-1:0]           ram_rdata,
   input  logic [CNT_W-1:0]            slot_cnt,
   output logic [PTR_W-1:0]            rptr,
   output logic                        release_slot,
   output logic                        rd_busy,
   output logic                        out_valid,
   output logic [BLK_ITEMS*DATA_W-1:0] out_data,
   output logic [CNT_W-1:0]            out_count
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_ITEMS - 1);

   unld_state_e      state;
   logic [IDX_W-1:0] rd_idx;
   logic             cap_valid;
   logic [IDX_W-1:0] cap_idx;

   assign ram_re       = (state == UNLD_FETCH);
   assign ram_raddr    = AW'(int'(rptr[SLOT_W-1:0]) * BLK_ITEMS + int'(rd_idx));
   assign release_slot = cap_valid && (cap_idx == LAST_IDX);
   assign rd_busy      = (state != UNLD_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= UNLD_IDLE;
         rd_idx    <= '0;
         cap_valid <= 1'b0;
         cap_idx   <= '0;
         out_valid <= 1'b0;
         out_count <= '0;
         rptr      <= '0;
      end else begin
         cap_valid <= ram_re;
         cap_idx   <= rd_idx;
         out_valid <= release_slot;
         if (release_slot) begin
            rptr      <= rptr + PTR_W'(1);
            out_count <= slot_cnt;
         end
         unique case (state)
            UNLD_IDLE: begin
               if (rd_req && blk_present) begin
                  state  <= UNLD_FETCH;
                  rd_idx <= '0;
               end
            end
            UNLD_FETCH: begin
               if (rd_idx == LAST_IDX) state <= UNLD_DRAIN;
               else                    rd_idx <= rd_idx + IDX_W'(1);
            end
            UNLD_DRAIN: begin
               if (release_slot) state <= UNLD_IDLE;
            end
            default: state <= UNLD_IDLE;
         endcase
      end
   end

   // wide output register, one lane per item
   generate
      for (genvar g = 0; g < BLK_ITEMS; g++) begin : g_lane
         logic [DATA_W-1:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lane_q <= '0;
            else if (cap_valid && (cap_idx == IDX_W'(g)))
               lane_q <= ram_rdata;
         end
         assign out_data[g*DATA_W +: DATA_W] = lane_q;
      end
   endgenerate

   assert_start_needs_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_busy) |-> $past(blk_present))
      else $error("unload started with no committed block");

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid)
      else $error("out_valid wider than one cycle");

   assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count >= CNT_W'(1) && out_count <= CNT_W'(BLK_ITEMS)))
      else $error("block count out of range");

endmodule

// File: rtl/blk_ring_buf.sv
module blk_ring_buf
   import blk_ring_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NUM_SLOTS = 4,
   parameter int BLK_ITEMS = 4,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int PTR_W    = SLOT_W + 1,
   localparam int CNT_W    = $clog2(BLK_ITEMS + 1),
   localparam int DEPTH    = NUM_SLOTS * BLK_ITEMS,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_valid,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        wr_last,
   output logic                        wr_ready,
   input  logic                        rd_req,
   output logic                        rd_busy,
   output logic                        out_valid,
   output logic [BLK_ITEMS*DATA_W-1:0] out_data,
   output logic [CNT_W-1:0]            out_count,
   output logic                        buf_full,
   output logic                        buf_empty
);

   initial begin
      assert_param_slots_R6: assert (NUM_SLOTS >= 2 && is_pow2(NUM_SLOTS))
         else $error("NUM_SLOTS must be a power of two, at least 2");
      assert_param_items_R2: assert (BLK_ITEMS >= 2)
         else $error("BLK_ITEMS must be at least 2");
      assert_param_width_R4: assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
   end

   localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(NUM_SLOTS);

   logic              ram_we, ram_re;
   logic [AW-1:0]     ram_waddr, ram_raddr;
   logic [DATA_W-1:0] ram_rdata;
   logic [PTR_W-1:0]  wptr, rptr, occ;
   logic              commit, release_slot;
   logic [CNT_W-1:0]  slot_cnt;

   // the wrap bit separates a full ring from an empty one
   assign occ       = wptr - rptr;
   assign buf_full  = (occ == FULL_OCC);
   assign buf_empty = (occ == '0);
   assign wr_ready  = !buf_full;

   blk_ring_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .wen   (ram_we),
      .waddr (ram_waddr),
      .wdata (wr_data),
      .ren   (ram_re),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   blk_ring_wr_ctrl #(.NUM_SLOTS(NUM_SLOTS), .BLK_ITEMS(BLK_ITEMS)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_last   (wr_last),
      .space_ok  (wr_ready),
      .ram_we    (ram_we),
      .ram_waddr (ram_waddr),
      .wptr      (wptr),
      .commit    (commit),
      .cnt_slot  (rptr[SLOT_W-1:0]),
      .cnt_val   (slot_cnt)
   );

   blk_ring_rd_ctrl #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .BLK_ITEMS(BLK_ITEMS)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_req       (rd_req),
      .blk_present  (!buf_empty),
      .ram_re       (ram_re),
      .ram_raddr    (ram_raddr),
      .ram_rdata    (ram_rdata),
      .slot_cnt     (slot_cnt),
      .rptr         (rptr),
      .release_slot (release_slot),
      .rd_busy      (rd_busy),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_count    (out_count)
   );

   assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= FULL_OCC)
      else $error("occupancy above slot count");

   assert_commit_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && release_slot) |=> (occ == $past(occ)))
      else $error("simultaneous commit and release changed occupancy");

   assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && !release_slot) |=> buf_full)
      else $error("full flag dropped without a release");

   assert_commit_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !buf_empty)
      else $error("committed block not visible");

endmodule

// File: tb/blk_ring_buf_tb.sv
module blk_ring_buf_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W     = 16;
   localparam int SLOTS = 4;
   localparam int K     = 4;
   localparam int CW    = $clog2(K + 1);

   logic           clk = 1'b0;
   logic           rst_n;
   logic           wr_valid, wr_last, wr_ready;
   logic [W-1:0]   wr_data;
   logic           rd_req, rd_busy, out_valid, buf_full, buf_empty;
   logic [K*W-1:0] out_data;
   logic [CW-1:0]  out_count;

   int total = 0;
   int bad   = 0;
   logic seen_ready;

   always #(CLK_PERIOD/2) clk = ~clk;

   blk_ring_buf #(.DATA_W(W), .NUM_SLOTS(SLOTS), .BLK_ITEMS(K)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
      .rd_req(rd_req), .rd_busy(rd_busy), .out_valid(out_valid),
      .out_data(out_data), .out_count(out_count),
      .buf_full(buf_full), .buf_empty(buf_empty)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // offer n items base..base+n-1, closing early with wr_last if asked
   task automatic put_block(input int base, input int n, input bit early);
      for (int i = 0; i < n; i++) begin
         wr_valid = 1'b1;
         wr_data  = W'(base + i);
         wr_last  = early && (i == n - 1);
         @(negedge clk);
      end
      wr_valid = 1'b0;
      wr_last  = 1'b0;
   endtask

   // unload oldest block and compare the valid lanes
   task automatic take_block(input int base, input int cnt, input string tag);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      check({tag, " R4 busy after start"}, int'(rd_busy), 1);
      repeat (K) @(negedge clk);
      check({tag, " R4 no pulse before due edge"}, int'(out_valid), 0);
      @(negedge clk);
      check({tag, " R4 out_valid at K+1"}, int'(out_valid), 1);
      check({tag, " R3 count"}, int'(out_count), cnt);
      for (int i = 0; i < cnt; i++)
         check({tag, " R5 lane data"}, int'(out_data[i*W +: W]), base + i);
      seen_ready = wr_ready;
      @(negedge clk);
      check({tag, " R4 pulse one cycle"}, int'(out_valid), 0);
   endtask

   task automatic t_reset();
      check("R1 empty", int'(buf_empty), 1);
      check("R1 full", int'(buf_full), 0);
      check("R1 wr_ready", int'(wr_ready), 1);
      check("R1 busy", int'(rd_busy), 0);
      check("R1 out_valid", int'(out_valid), 0);
   endtask

   task automatic t_empty_request();
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      check("R9 no start when empty", int'(rd_busy), 0);
      for (int c = 0; c < K + 2; c++) begin
         @(negedge clk);
         check("R9 no pulse when empty", int'(out_valid), 0);
      end
   endtask

   task automatic t_single_block();
      put_block(16'h1000, K - 1, 1'b0);
      check("R2 incomplete block hidden", int'(buf_empty), 1);
      put_block(16'h1000 + K - 1, 1, 1'b0);
      check("R2 visible after commit", int'(buf_empty), 0);
      take_block(16'h1000, K, "single");
      check("R2 empty after unload", int'(buf_empty), 1);
   endtask

   task automatic t_full();
      for (int b = 0; b < SLOTS; b++) put_block(16'h2000 + 16'h100*b, K, 1'b0);
      check("R6 full flag", int'(buf_full), 1);
      check("R6 wr_ready low", int'(wr_ready), 0);
      wr_valid = 1'b1; wr_last = 1'b1; wr_data = 16'hDEAD;
      repeat (3) @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
      check("R6 still full", int'(buf_full), 1);
      take_block(16'h2000, K, "full0");
      check("R7 wr_ready with out_valid", int'(seen_ready), 1);
      check("R7 not full after release", int'(buf_full), 0);
      for (int b = 1; b < SLOTS; b++) take_block(16'h2000 + 16'h100*b, K, "full");
      check("R6 dropped items made no block", int'(buf_empty), 1);
   endtask

   task automatic t_overlap();
      for (int b = 0; b < SLOTS - 1; b++) put_block(16'h3000 + 16'h100*b, K, 1'b0);
      // the last item of the new block lands on the release edge
      for (int n = 0; n < K + 2; n++) begin
         rd_req   = (n == 0);
         wr_valid = (n >= 2);
         wr_last  = 1'b0;
         wr_data  = W'(16'h3300 + n - 2);
         @(negedge clk);
      end
      rd_req = 1'b0; wr_valid = 1'b0;
      check("R10 out_valid during writes", int'(out_valid), 1);
      for (int i = 0; i < K; i++)
         check("R10 unloaded block intact", int'(out_data[i*W +: W]), 16'h3000 + i);
      check("R8 occupancy kept, not full", int'(buf_full), 0);
      check("R8 occupancy kept, not empty", int'(buf_empty), 0);
      put_block(16'h3400, K, 1'b0);
      check("R8 one more block fills ring", int'(buf_full), 1);
      for (int b = 1; b < SLOTS + 1; b++) take_block(16'h3000 + 16'h100*b, K, "wrap");
      check("R5 drained", int'(buf_empty), 1);
   endtask

   task automatic t_short();
      put_block(16'h4000, 2, 1'b1);
      check("R3 short block committed", int'(buf_empty), 0);
      put_block(16'h4100, 1, 1'b1);
      put_block(16'h4200, K, 1'b1);
      take_block(16'h4000, 2, "short2");
      take_block(16'h4100, 1, "short1");
      take_block(16'h4200, K, "lastK");
   endtask

   initial begin
      rst_n = 1'b0; wr_valid = 1'b0; wr_last = 1'b0; wr_data = '0; rd_req = 1'b0;
      seen_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_empty_request();
      t_single_block();
      t_full();
      t_overlap();
      t_short();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule